// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds the eight 80-bit extended-precision registers of a floating-point unit. It treats them as a stack by rotating a 3-bit top pointer over a fixed register file, not by shifting data. Each physical register has an empty flag. Operands are named relative to the top: relative index `i` selects physical register `(top + i) mod 8`.

One stack command is accepted per cycle on `cmd_op`. The commands are push, pop, pointer decrement, pointer increment, free-at-offset, mark-all-empty and mark-all-valid. One relative write port and one relative read port carry register data. The block keeps a stored status word and returns it with the pointer inserted in bits 13:11. It derives two tag encodings from the empty flags and the register contents: a two-bit-per-register word and a one-bit-per-register byte. A status word, a two-bit tag word or a one-bit tag byte can be loaded to restore a saved environment.

The block always accepts what it is given, so there is no back-pressure. The write port is a plain enable, and the command, load and read pins are plain control pins. State changes at the rising clock edge. All outputs are combinational views of the registered state.

Top module: `fpstk_ctrl`

## Requirements
- R1: After reset, the top pointer is 0, every register is empty (`tag_abr` = 8'h00, `tag_full` = 16'hFFFF) and `status_word` is 0.
- R2: Push (`cmd_op` = 1) sets the top pointer to (top − 1) mod 8 and marks the new top register not empty.
- R3: Pop (`cmd_op` = 2) marks the current top register empty and sets the top pointer to (top + 1) mod 8.
- R4: Free (`cmd_op` = 5) marks physical register (top + `cmd_idx`) mod 8 empty and leaves the pointer unchanged.
- R5: Pointer decrement (`cmd_op` = 3) and pointer increment (`cmd_op` = 4) move only the pointer, by −1 or +1 mod 8. They clear stored status bits 14, 10, 9 and 8 (mask 16'h4700) and leave the tags unchanged.
- R6: `status_word` equals the stored status with bits 13:11 replaced by the top pointer. A status load (`ld_sw_en`) takes the pointer from `ld_sw[13:11]` and stores the other bits, so `status_word` reads back exactly `ld_sw` in the next cycle.
- R7: The read port returns physical register (top + `rd_idx`) mod 8. A write goes to (top' + `wr_idx`) mod 8, where top' is the pointer after the same cycle's command and loads. A push with a write at index 0 therefore fills the new top.
- R8: `tag_full[2p+1:2p]` describes physical register p. The code is 11 when the register is empty. Otherwise it is 01 for zero (exponent bits 78:64 and mantissa bits 63:0 all zero), 10 for special (exponent zero, exponent all ones, or mantissa bit 63 clear) and 00 for valid.
- R9: `tag_abr[p]` is 1 exactly when physical register p is not empty, which matches `tag_full` pair p not being 11.
- R10: A two-bit tag load (`ld_tag_full_en`) marks register p empty only when `ld_tag_full[2p+1:2p]` is 11.
- R11: A one-bit tag load (`ld_tag_abr_en`) marks register p not empty when `ld_tag_abr[p]` is 1, and empty otherwise.
- R12: Mark-all-empty (`cmd_op` = 6) empties all eight registers and leaves the pointer unchanged. Mark-all-valid (`cmd_op` = 7) marks all eight not empty and sets the pointer to 0.
- R13: A status load in the same cycle as a command overrides the command's effect on the pointer and the stored status. A tag load overrides the command's effect on the tags. A two-bit tag load wins over a one-bit tag load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Stack command: 0 none, 1 push, 2 pop, 3 decrement, 4 increment, 5 free, 6 all empty, 7 all valid |
| cmd_idx | input | 3 | Relative index for free |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Relative write index (against the post-command pointer) |
| wr_data | input | 80 | Write data: sign 79, exponent 78:64, mantissa 63:0 |
| rd_idx | input | 3 | Relative read index |
| rd_data | output | 80 | Read data |
| ld_sw_en | input | 1 | Load the status word |
| ld_sw | input | 16 | Status word to load |
| ld_tag_full_en | input | 1 | Load the two-bit tag word |
| ld_tag_full | input | 16 | Two-bit tag word to load |
| ld_tag_abr_en | input | 1 | Load the one-bit tag byte |
| ld_tag_abr | input | 8 | One-bit tag byte to load |
| top | output | 3 | Current top pointer |
| status_word | output | 16 | Stored status with the pointer in bits 13:11 |
| tag_full | output | 16 | Two bits per physical register |
| tag_abr | output | 8 | One bit per physical register, 1 = not empty |

## Verification
Every command, load and write is captured at one rising edge. `top`, `status_word`, `tag_abr`, `tag_full` and `rd_data` show the result right after that edge, so each result is due one cycle after its stimulus. `rd_data` is combinational from the current pointer and index. `tag_full` depends on register contents written in that same edge. The bench applies each stimulus just after a rising edge, waits one full edge, clears the inputs and compares shortly after that edge. The clocked properties use a single-cycle implication to express the same one-cycle latency.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_DECTOP  = 3'd3,
    OP_INCTOP  = 3'd4,
    OP_FREE    = 3'd5,
    OP_KILLALL = 3'd6,
    OP_FILLALL = 3'd7
  } stk_op_e;

  // two-bit tag codes
  localparam logic [1:0] TG_VALID   = 2'b00;
  localparam logic [1:0] TG_ZERO    = 2'b01;
  localparam logic [1:0] TG_SPECIAL = 2'b10;
  localparam logic [1:0] TG_EMPTY   = 2'b11;

  localparam int SW_W    = 16;
  localparam int TOP_LSB = 11;
  localparam logic [SW_W-1:0] CC_MASK = 16'h4700;

endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr
  import fpstk_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic             ld_sw_en,
  input  logic [SW_W-1:0]  ld_sw,
  output logic [PTR_W-1:0] top_q,
  output logic [PTR_W-1:0] top_nxt,
  output logic [SW_W-1:0]  sts_q
);

  localparam logic [SW_W-1:0] TOP_FIELD = SW_W'(((1 << PTR_W) - 1) << TOP_LSB);

  logic [SW_W-1:0] sts_nxt;

  always_comb begin
    top_nxt = top_q;
    sts_nxt = sts_q;
    unique case (op)
      OP_PUSH, OP_DECTOP: top_nxt = top_q - 1'b1;
      OP_POP, OP_INCTOP:  top_nxt = top_q + 1'b1;
      OP_FILLALL:         top_nxt = '0;
      default:            top_nxt = top_q;
    endcase
    if (op == OP_DECTOP || op == OP_INCTOP)
      sts_nxt = sts_q & ~CC_MASK;
    if (ld_sw_en) begin
      top_nxt = ld_sw[TOP_LSB +: PTR_W];
      sts_nxt = ld_sw & ~TOP_FIELD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      sts_q <= '0;
    end else begin
      top_q <= top_nxt;
      sts_q <= sts_nxt;
    end
  end

endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags
  import fpstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int PTR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [PTR_W-1:0]  op_idx,
  input  logic [PTR_W-1:0]  top_q,
  input  logic              ld_full_en,
  input  logic [2*NREG-1:0] ld_full,
  input  logic              ld_abr_en,
  input  logic [NREG-1:0]   ld_abr,
  output logic [NREG-1:0]   empty_q
);

  logic [PTR_W-1:0] push_reg;
  logic [PTR_W-1:0] free_reg;

  assign push_reg = top_q - 1'b1;
  assign free_reg = top_q + op_idx;

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    localparam logic [PTR_W-1:0] ME = PTR_W'(g);
    logic nxt;

    always_comb begin
      nxt = empty_q[g];
      if (ld_full_en)
        nxt = (ld_full[2*g +: 2] == TG_EMPTY);
      else if (ld_abr_en)
        nxt = ~ld_abr[g];
      else begin
        unique case (op)
          OP_PUSH:    if (push_reg == ME) nxt = 1'b0;
          OP_POP:     if (top_q == ME)    nxt = 1'b1;
          OP_FREE:    if (free_reg == ME) nxt = 1'b1;
          OP_KILLALL: nxt = 1'b1;
          OP_FILLALL: nxt = 1'b0;
          default:    nxt = empty_q[g];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_q[g] <= 1'b1;
      else        empty_q[g] <= nxt;
    end
  end

endmodule

// File: rtl/fpstk_rf.sv
module fpstk_rf #(
  parameter int NREG  = 8,
  parameter int VAL_W = 80,
  parameter int PTR_W = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_phys,
  input  logic [VAL_W-1:0]           wr_data,
  input  logic [PTR_W-1:0]           rd_phys,
  output logic [VAL_W-1:0]           rd_data,
  output logic [NREG-1:0][VAL_W-1:0] regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_o[g] <= '0;
      else if (wr_en && wr_phys == PTR_W'(g))
        regs_o[g] <= wr_data;
    end
  end

  assign rd_data = regs_o[rd_phys];

endmodule

// File: rtl/fpstk_tagenc.sv
module fpstk_tagenc
  import fpstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  parameter int VAL_W = 1 + EXP_W + MAN_W
) (
  input  logic [NREG-1:0][VAL_W-1:0] regs,
  input  logic [NREG-1:0]            empty,
  output logic [2*NREG-1:0]          tag_full,
  output logic [NREG-1:0]            tag_abr
);

  for (genvar g = 0; g < NREG; g++) begin : g_cls
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic [1:0]       code;

    assign ex = regs[g][MAN_W +: EXP_W];
    assign mn = regs[g][MAN_W-1:0];

    always_comb begin
      if (empty[g])
        code = TG_EMPTY;
      else if (ex == '0 && mn == '0)
        code = TG_ZERO;
      else if (ex == '0 || ex == '1 || !mn[MAN_W-1])
        code = TG_SPECIAL;
      else
        code = TG_VALID;
    end

    assign tag_full[2*g +: 2] = code;
    assign tag_abr[g]         = ~empty[g];
  end

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int PTR_W = $clog2(NREG),
  localparam int VAL_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [VAL_W-1:0]  rd_data,
  input  logic              ld_sw_en,
  input  logic [SW_W-1:0]   ld_sw,
  input  logic              ld_tag_full_en,
  input  logic [2*NREG-1:0] ld_tag_full,
  input  logic              ld_tag_abr_en,
  input  logic [NREG-1:0]   ld_tag_abr,
  output logic [PTR_W-1:0]  top,
  output logic [SW_W-1:0]   status_word,
  output logic [2*NREG-1:0] tag_full,
  output logic [NREG-1:0]   tag_abr
);

  stk_op_e                   op;
  logic [PTR_W-1:0]          top_q;
  logic [PTR_W-1:0]          top_nxt;
  logic [SW_W-1:0]           sts_q;
  logic [NREG-1:0]           empty_q;
  logic [NREG-1:0][VAL_W-1:0] regs;

  assign op = stk_op_e'(cmd_op);

  fpstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ld_sw_en (ld_sw_en),
    .ld_sw    (ld_sw),
    .top_q    (top_q),
    .top_nxt  (top_nxt),
    .sts_q    (sts_q)
  );

  fpstk_tags #(.NREG(NREG), .PTR_W(PTR_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .op_idx     (cmd_idx),
    .top_q      (top_q),
    .ld_full_en (ld_tag_full_en),
    .ld_full    (ld_tag_full),
    .ld_abr_en  (ld_tag_abr_en),
    .ld_abr     (ld_tag_abr),
    .empty_q    (empty_q)
  );

  fpstk_rf #(.NREG(NREG), .VAL_W(VAL_W), .PTR_W(PTR_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_phys (top_nxt + wr_idx),
    .wr_data (wr_data),
    .rd_phys (top_q + rd_idx),
    .rd_data (rd_data),
    .regs_o  (regs)
  );

  fpstk_tagenc #(.NREG(NREG), .EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_enc (
    .regs     (regs),
    .empty    (empty_q),
    .tag_full (tag_full),
    .tag_abr  (tag_abr)
  );

  always_comb begin
    status_word = sts_q;
    status_word[TOP_LSB +: PTR_W] = top_q;
  end

  assign top = top_q;

endmodule

// File: rtl/fpstk_ctrl_chk.sv
module fpstk_ctrl_chk
  import fpstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int PTR_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_op,
  input logic              ld_sw_en,
  input logic [SW_W-1:0]   ld_sw,
  input logic              ld_tag_full_en,
  input logic              ld_tag_abr_en,
  input logic [PTR_W-1:0]  top,
  input logic [SW_W-1:0]   status_word,
  input logic [2*NREG-1:0] tag_full,
  input logic [NREG-1:0]   tag_abr
);

  logic no_tld;
  assign no_tld = !ld_tag_full_en && !ld_tag_abr_en;

  assert_push_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_PUSH && !ld_sw_en) |=> top == PTR_W'($past(top) - 1'b1));

  assert_push_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_PUSH && !ld_sw_en && no_tld) |=> tag_abr[top]);

  assert_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_POP && !ld_sw_en && no_tld) |=>
      (top == PTR_W'($past(top) + 1'b1)) && !tag_abr[$past(top)]);

  assert_cc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == OP_DECTOP || cmd_op == OP_INCTOP) && !ld_sw_en) |=>
      (status_word & CC_MASK) == '0);

  assert_sw_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sw_en |=> status_word == $past(ld_sw));

  assert_kill_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_KILLALL && no_tld) |=> tag_abr == '0);

  assert_fill_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_FILLALL && no_tld && !ld_sw_en) |=> (tag_abr == '1) && (top == '0));

  for (genvar g = 0; g < NREG; g++) begin : g_cons
    assert_tag_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tag_abr[g] == (tag_full[2*g +: 2] != TG_EMPTY));
  end

endmodule

bind fpstk_ctrl fpstk_ctrl_chk #(.NREG(NREG)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_op         (cmd_op),
  .ld_sw_en       (ld_sw_en),
  .ld_sw          (ld_sw),
  .ld_tag_full_en (ld_tag_full_en),
  .ld_tag_abr_en  (ld_tag_abr_en),
  .top            (top),
  .status_word    (status_word),
  .tag_full       (tag_full),
  .tag_abr        (tag_abr)
);

// File: tb/sim_fpstk_ctrl.sv
module sim_fpstk_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_idx = 3'd0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = 3'd0;
  logic [79:0] wr_data = '0;
  logic [2:0]  rd_idx = 3'd0;
  logic [79:0] rd_data;
  logic        ld_sw_en = 1'b0;
  logic [15:0] ld_sw = '0;
  logic        ld_tag_full_en = 1'b0;
  logic [15:0] ld_tag_full = '0;
  logic        ld_tag_abr_en = 1'b0;
  logic [7:0]  ld_tag_abr = '0;
  logic [2:0]  top;
  logic [15:0] status_word;
  logic [15:0] tag_full;
  logic [7:0]  tag_abr;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [79:0] VAL_A = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] VAL_B = 80'h0;
  localparam logic [79:0] VAL_C = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] VAL_D = {1'b1, 15'h4001, 64'hC000_0000_0000_0000};
  localparam logic [79:0] VAL_E = {1'b0, 15'h1234, 64'h4000_0000_0000_0001};

  always #(CLK_PERIOD/2) clk = ~clk;

  fpstk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .ld_sw_en(ld_sw_en), .ld_sw(ld_sw),
    .ld_tag_full_en(ld_tag_full_en), .ld_tag_full(ld_tag_full),
    .ld_tag_abr_en(ld_tag_abr_en), .ld_tag_abr(ld_tag_abr),
    .top(top), .status_word(status_word), .tag_full(tag_full), .tag_abr(tag_abr)
  );

  task automatic chk(input string req, input string what,
                     input logic [79:0] got, input logic [79:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    cmd_op = 3'd0; cmd_idx = 3'd0; wr_en = 1'b0; wr_idx = 3'd0;
    ld_sw_en = 1'b0; ld_tag_full_en = 1'b0; ld_tag_abr_en = 1'b0;
  endtask

  // capture at the next rising edge, then sample 1 time unit later
  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1", "top", 80'(top), 80'd0);
    chk("R1", "tag_abr", 80'(tag_abr), 80'h00);
    chk("R1", "tag_full", 80'(tag_full), 80'hFFFF);
    chk("R1", "status", 80'(status_word), 80'h0);
  endtask

  task automatic t_push();
    cmd_op = 3'd1; wr_en = 1'b1; wr_idx = 3'd0; wr_data = VAL_A; tick();
    chk("R2", "top after push", 80'(top), 80'd7);
    chk("R2", "tag_abr after push", 80'(tag_abr), 80'h80);
    chk("R6", "status top field", 80'(status_word), 80'h3800);
    rd_idx = 3'd0; #1;
    chk("R7", "read new top", rd_data, VAL_A);
    chk("R8", "valid code", 80'(tag_full), 80'h3FFF);
    cmd_op = 3'd1; wr_en = 1'b1; wr_idx = 3'd0; wr_data = VAL_B; tick();
    chk("R8", "zero code", 80'(tag_full), 80'h1FFF);
    rd_idx = 3'd1; #1;
    chk("R7", "read ST1", rd_data, VAL_A);
    cmd_op = 3'd1; wr_en = 1'b1; wr_idx = 3'd0; wr_data = VAL_C; tick();
    chk("R8", "special code", 80'(tag_full), 80'h1BFF);
    chk("R2", "top after 3 pushes", 80'(top), 80'd5);
  endtask

  task automatic t_pop_free();
    cmd_op = 3'd2; tick();
    chk("R3", "top after pop", 80'(top), 80'd6);
    chk("R3", "tag_abr after pop", 80'(tag_abr), 80'hC0);
    chk("R9", "tag_full after pop", 80'(tag_full), 80'h1FFF);
    cmd_op = 3'd5; cmd_idx = 3'd1; tick();
    chk("R4", "tag_abr after free", 80'(tag_abr), 80'h40);
    chk("R4", "top after free", 80'(top), 80'd6);
    chk("R9", "tag_full after free", 80'(tag_full), 80'hDFFF);
  endtask

  task automatic t_pointer_cmds();
    ld_sw_en = 1'b1; ld_sw = 16'hFFFF; tick();
    chk("R6", "top from load", 80'(top), 80'd7);
    chk("R6", "status readback", 80'(status_word), 80'hFFFF);
    cmd_op = 3'd4; tick();
    chk("R5", "status after inc", 80'(status_word), 80'h80FF);
    chk("R5", "top after inc", 80'(top), 80'd0);
    chk("R5", "tags kept", 80'(tag_abr), 80'h40);
    cmd_op = 3'd3; tick();
    chk("R5", "status after dec", 80'(status_word), 80'hB8FF);
  endtask

  task automatic t_all();
    cmd_op = 3'd7; tick();
    chk("R12", "fill tag_abr", 80'(tag_abr), 80'hFF);
    chk("R12", "fill top", 80'(top), 80'd0);
    chk("R8", "mixed classes", 80'(tag_full), 80'h1955);
    cmd_op = 3'd6; tick();
    chk("R12", "kill tag_abr", 80'(tag_abr), 80'h00);
    chk("R12", "kill top", 80'(top), 80'd0);
    chk("R12", "kill tag_full", 80'(tag_full), 80'hFFFF);
  endtask

  task automatic t_tag_loads();
    ld_tag_full_en = 1'b1; ld_tag_full = 16'hC6F1; tick();
    chk("R10", "tag_abr from word", 80'(tag_abr), 80'h73);
    chk("R10", "tag_full reclassified", 80'(tag_full), 80'hD9F5);
    ld_tag_abr_en = 1'b1; ld_tag_abr = 8'hA5; tick();
    chk("R11", "tag_abr from byte", 80'(tag_abr), 80'hA5);
  endtask

  task automatic t_wrap_write();
    cmd_op = 3'd7; tick();
    cmd_op = 3'd2; tick();
    chk("R3", "pop at 0 wraps", 80'(top), 80'd1);
    chk("R3", "reg0 emptied", 80'(tag_abr), 80'hFE);
    cmd_op = 3'd1; wr_en = 1'b1; wr_idx = 3'd0; wr_data = VAL_D; tick();
    chk("R2", "push back to 0", 80'(top), 80'd0);
    rd_idx = 3'd0; #1;
    chk("R7", "push+write lands on new top", rd_data, VAL_D);
    wr_en = 1'b1; wr_idx = 3'd2; wr_data = VAL_E; tick();
    rd_idx = 3'd2; #1;
    chk("R7", "relative write ST2", rd_data, VAL_E);
    chk("R8", "mantissa bit63 clear special", 80'(tag_full[5:4]), 80'd2);
  endtask

  task automatic t_override();
    cmd_op = 3'd1; ld_sw_en = 1'b1; ld_sw = 16'h2000; tick();
    chk("R13", "status load beats push", 80'(top), 80'd4);
    chk("R13", "status value", 80'(status_word), 80'h2000);
    cmd_op = 3'd6; ld_tag_abr_en = 1'b1; ld_tag_abr = 8'h0F; tick();
    chk("R13", "tag load beats kill", 80'(tag_abr), 80'h0F);
    ld_tag_full_en = 1'b1; ld_tag_full = 16'h0000;
    ld_tag_abr_en = 1'b1; ld_tag_abr = 8'h00; tick();
    chk("R13", "word beats byte", 80'(tag_abr), 80'hFF);
  endtask

  initial begin
    idle();
    t_reset();
    t_push();
    t_pop_free();
    t_pointer_cmds();
    t_all();
    t_tag_loads();
    t_wrap_write();
    t_override();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule